// File: doc/BRIEF.md
# Single-Cycle Processor Datapath

This block is the 32-bit execution core of a small load/store processor in which every instruction finishes in one clock. In each cycle it presents the program counter to an external instruction store and receives the operand fields of the fetched word. It reads two source registers, sign-extends the 16-bit immediate and runs the ALU. The ALU result goes out as the data address, and the second register goes out as the store data. The value to keep, either the ALU result or the returned memory word, is written back to the register file at the closing clock edge, and the program counter moves to its successor at that same edge.

All decisions arrive as inputs from a separate decoder that sees the opcode and function fields. The block exports the ALU zero flag so that the decoder can form the branch-taken select. The successor PC is one of three values: the incremented PC, a branch target relative to the incremented PC, or a jump target within the same 256 MB region. There is no state machine. The only sequential state is the PC register (named state IDLE-free: it simply advances once per clock, and synchronous reset is the only transition back to address zero) and the register array.

Top module: `sc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_out` becomes 0 after that edge; register contents are not reset.
- R2: With `ctl_jump`=0 and `ctl_take_br`=0, the next PC is `pc_out`+4.
- R3: With `ctl_take_br`=1 and `ctl_jump`=0, the next PC is `pc_out`+4 plus the sign-extended immediate (bits 15:0) shifted left by two; negative offsets branch backwards.
- R4: With `ctl_jump`=1, the next PC is bits 31:28 of `pc_out`+4, then operand bits 25:0, then two zero bits, whatever `ctl_take_br` is.
- R5: Source A is the register addressed by operand bits 25:21 and source B the register addressed by bits 20:16; source B is always driven on `wdata_out`.
- R6: The destination register is bits 15:11 when `ctl_dst_rd`=1 and bits 20:16 when it is 0.
- R7: The second ALU operand is the sign-extended immediate when `ctl_imm_b`=1 and source B when it is 0.
- R8: The written-back value is `rdata_in` when `ctl_wb_mem`=1 and the ALU result when it is 0.
- R9: ALU codes: 000 AND, 001 OR, 010 ADD, 110 SUB, 111 set-on-less-than; 100 AND with inverted B and 101 OR with inverted B; 011 yields zero. The result drives `addr_out`.
- R10: `zero_out` is 1 exactly when the ALU result is zero.
- R11: Register 0 always reads as zero, and writes to it have no effect.
- R12: The register file is written only at a rising edge with `ctl_regwr`=1; otherwise no register changes.
- R13: Set-on-less-than compares the operands as signed two's-complement numbers and yields 1 or 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the PC |
| ctl_regwr | input | 1 | Write enable for the register file |
| ctl_dst_rd | input | 1 | Destination select: 1 = bits 15:11, 0 = bits 20:16 |
| ctl_imm_b | input | 1 | ALU operand B select: 1 = sign-extended immediate |
| ctl_wb_mem | input | 1 | Write-back select: 1 = memory read data |
| ctl_take_br | input | 1 | Branch taken (branch AND zero), selects branch target |
| ctl_jump | input | 1 | Selects the pseudo-direct jump target |
| ctl_alu | input | 3 | ALU operation code |
| instr_in | input | 26 | Operand fields (bits 25:0) of the fetched instruction |
| rdata_in | input | 32 | Data memory read word |
| pc_out | output | 32 | Current program counter |
| addr_out | output | 32 | ALU result, used as data address |
| wdata_out | output | 32 | Store data (source B register) |
| zero_out | output | 1 | ALU result is zero |

## Verification
Register write-back and PC redirection share every clock edge, and the sharpest case is a load whose write-back must be visible to the very next instruction, a compare-and-branch on the loaded register. A short program has a load followed at once by such a branch, and both words written after it must be skipped if the branch is taken. The outcome is judged at the ports. The PC trace must jump over the two skipped words, and a later store of the register they would have written must still show its earlier value. A jump placed after further stores, and a final backward self-branch, check that the redirect and the hold at the halt loop leave the stored results intact.

// File: rtl/scdp_pkg.sv
package scdp_pkg;

    typedef enum logic [2:0] {
        ALU_AND  = 3'b000,
        ALU_OR   = 3'b001,
        ALU_ADD  = 3'b010,
        ALU_NONE = 3'b011,
        ALU_ANDN = 3'b100,
        ALU_ORN  = 3'b101,
        ALU_SUB  = 3'b110,
        ALU_SLT  = 3'b111
    } alu_op_e;

    localparam int IMM_W  = 16;
    localparam int FLD_W  = 26;
    localparam int REG_AW = 5;

endpackage

// File: rtl/scdp_regfile.sv
module scdp_regfile #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] regs [DEPTH];

    assign regs[0] = '0;

    for (genvar g = 1; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (we && (wa == AW'(g))) begin
                regs[g] <= wd;
            end
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

endmodule

// File: rtl/scdp_alu.sv
module scdp_alu
    import scdp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [2:0]    op,
    output logic [DW-1:0] res,
    output logic          zero
);
    always_comb begin
        unique case (alu_op_e'(op))
            ALU_AND:  res = opa & opb;
            ALU_OR:   res = opa | opb;
            ALU_ADD:  res = opa + opb;
            ALU_ANDN: res = opa & ~opb;
            ALU_ORN:  res = opa | ~opb;
            ALU_SUB:  res = opa - opb;
            ALU_SLT:  res = DW'($signed(opa) < $signed(opb));
            default:  res = '0;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/scdp_nextpc.sv
module scdp_nextpc
    import scdp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_br,
    input  logic             jump,
    input  logic [DW-1:0]    sext,
    input  logic [FLD_W-1:0] jfield,
    output logic [DW-1:0]    pc
);
    localparam int HI_W = DW - FLD_W - 2;

    logic [DW-1:0] pc_inc;
    logic [DW-1:0] pc_br;
    logic [DW-1:0] pc_jmp;
    logic [DW-1:0] pc_nxt;

    assign pc_inc = pc + DW'(4);
    assign pc_br  = pc_inc + {sext[DW-3:0], 2'b00};
    assign pc_jmp = {pc_inc[DW-1 -: HI_W], jfield, 2'b00};

    always_comb begin
        if (jump) begin
            pc_nxt = pc_jmp;
        end else if (take_br) begin
            pc_nxt = pc_br;
        end else begin
            pc_nxt = pc_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_nxt;
        end
    end

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
    import scdp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_regwr,
    input  logic             ctl_dst_rd,
    input  logic             ctl_imm_b,
    input  logic             ctl_wb_mem,
    input  logic             ctl_take_br,
    input  logic             ctl_jump,
    input  logic [2:0]       ctl_alu,
    input  logic [FLD_W-1:0] instr_in,
    input  logic [DW-1:0]    rdata_in,
    output logic [DW-1:0]    pc_out,
    output logic [DW-1:0]    addr_out,
    output logic [DW-1:0]    wdata_out,
    output logic             zero_out
);
    logic [REG_AW-1:0] f_src_a;
    logic [REG_AW-1:0] f_src_b;
    logic [REG_AW-1:0] f_dst;
    logic [IMM_W-1:0]  f_imm;
    logic [REG_AW-1:0] dst_sel;
    logic [DW-1:0]     imm_ext;
    logic [DW-1:0]     reg_a;
    logic [DW-1:0]     reg_b;
    logic [DW-1:0]     alu_b;
    logic [DW-1:0]     alu_y;
    logic [DW-1:0]     wb_val;

    // operand field extraction; positions are fixed by the instruction format
    assign f_src_a = instr_in[25:21];
    assign f_src_b = instr_in[20:16];
    assign f_dst   = instr_in[15:11];
    assign f_imm   = instr_in[IMM_W-1:0];

    assign imm_ext = {{(DW-IMM_W){f_imm[IMM_W-1]}}, f_imm};
    assign dst_sel = ctl_dst_rd ? f_dst : f_src_b;
    assign alu_b   = ctl_imm_b ? imm_ext : reg_b;
    assign wb_val  = ctl_wb_mem ? rdata_in : alu_y;

    scdp_regfile #(.DW(DW), .AW(REG_AW)) u_rf (
        .clk  (clk),
        .we   (ctl_regwr),
        .ra_a (f_src_a),
        .ra_b (f_src_b),
        .wa   (dst_sel),
        .wd   (wb_val),
        .rd_a (reg_a),
        .rd_b (reg_b)
    );

    scdp_alu #(.DW(DW)) u_alu (
        .opa  (reg_a),
        .opb  (alu_b),
        .op   (ctl_alu),
        .res  (alu_y),
        .zero (zero_out)
    );

    scdp_nextpc #(.DW(DW)) u_npc (
        .clk     (clk),
        .rst     (rst),
        .take_br (ctl_take_br),
        .jump    (ctl_jump),
        .sext    (imm_ext),
        .jfield  (instr_in),
        .pc      (pc_out)
    );

    assign addr_out  = alu_y;
    assign wdata_out = reg_b;

endmodule

// File: rtl/sc_datapath_chk.sv
module sc_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctl_imm_b,
    input logic        ctl_take_br,
    input logic        ctl_jump,
    input logic [2:0]  ctl_alu,
    input logic [25:0] instr_in,
    input logic [31:0] pc_out,
    input logic [31:0] addr_out,
    input logic [31:0] wdata_out
);
    logic [31:0] pc4_c;
    logic [31:0] sext_c;
    logic [31:0] btgt_c;
    logic [31:0] jtgt_c;

    assign pc4_c  = pc_out + 32'd4;
    assign sext_c = {{16{instr_in[15]}}, instr_in[15:0]};
    assign btgt_c = pc4_c + (sext_c << 2);
    assign jtgt_c = {pc4_c[31:28], instr_in, 2'b00};

    AST_PC_RESET: assert property (@(posedge clk) rst |=> (pc_out == 32'd0)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ctl_jump && !ctl_take_br) |=> (pc_out == $past(pc4_c))); // R2

    AST_PC_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (ctl_take_br && !ctl_jump) |=> (pc_out == $past(btgt_c))); // R3

    AST_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
        ctl_jump |=> (pc_out == $past(jtgt_c))); // R4

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (instr_in[20:16] == 5'd0) |-> (wdata_out == 32'd0)); // R11

    AST_IMM_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (ctl_imm_b && ctl_alu == 3'b010 && instr_in[25:21] == 5'd0) |-> (addr_out == sext_c)); // R7

endmodule

bind sc_datapath sc_datapath_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_imm_b   (ctl_imm_b),
    .ctl_take_br (ctl_take_br),
    .ctl_jump    (ctl_jump),
    .ctl_alu     (ctl_alu),
    .instr_in    (instr_in),
    .pc_out      (pc_out),
    .addr_out    (addr_out),
    .wdata_out   (wdata_out)
);

// File: tb/sc_datapath_bench.sv
module sc_datapath_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c_regwr, c_dst, c_immb, c_wbm, c_br, c_jmp, c_take;
    logic [2:0]  c_alu;
    logic [31:0] word, rdata, pc, addr, wdata;
    logic        zero;
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          n_chk = 0;
    int          n_err = 0;

    always #2 clk = ~clk;

    sc_datapath u_sc_datapath (
        .clk         (clk),
        .rst         (rst),
        .ctl_regwr   (c_regwr),
        .ctl_dst_rd  (c_dst),
        .ctl_imm_b   (c_immb),
        .ctl_wb_mem  (c_wbm),
        .ctl_take_br (c_take),
        .ctl_jump    (c_jmp),
        .ctl_alu     (c_alu),
        .instr_in    (word[25:0]),
        .rdata_in    (rdata),
        .pc_out      (pc),
        .addr_out    (addr),
        .wdata_out   (wdata),
        .zero_out    (zero)
    );

    // behavioural memories and decoder
    assign word   = imem[pc[7:2]];
    assign rdata  = dmem[addr[7:2]];
    assign c_take = c_br & zero;
    logic c_mw;

    always_comb begin
        {c_regwr, c_dst, c_immb, c_wbm, c_br, c_jmp, c_mw} = '0;
        c_alu = 3'b010;
        case (word[31:26])
            6'h00: begin
                c_regwr = 1'b1; c_dst = 1'b1;
                case (word[5:0])
                    6'h20: c_alu = 3'b010;
                    6'h22: c_alu = 3'b110;
                    6'h24: c_alu = 3'b000;
                    6'h25: c_alu = 3'b001;
                    6'h2A: c_alu = 3'b111;
                    default: c_alu = 3'b011;
                endcase
            end
            6'h23: begin c_regwr = 1'b1; c_immb = 1'b1; c_wbm = 1'b1; end
            6'h2B: begin c_immb = 1'b1; c_mw = 1'b1; end
            6'h04: begin c_br = 1'b1; c_alu = 3'b110; end
            6'h08: begin c_regwr = 1'b1; c_immb = 1'b1; end
            6'h02: c_jmp = 1'b1;
            default: ;
        endcase
    end

    always @(posedge clk) begin
        if (c_mw && !rst) dmem[addr[7:2]] <= wdata;
    end

    function automatic logic [31:0] e_r(int rs, int rt, int rd, int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] e_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nxt_idx(int i);
        if (i == 18) return 21;
        if (i == 24) return 26;
        if (i == 27) return 27;
        return i + 1;
    endfunction

    task automatic t_load_program();
        for (int i = 0; i < 64; i++) begin
            imem[i] = e_i(6'h04, 0, 0, -1);
            dmem[i] = 32'hDEAD_0000 + 32'(i);
        end
        imem[0]  = e_i(6'h08, 0, 1, 5);
        imem[1]  = e_i(6'h08, 0, 2, -3);
        imem[2]  = e_r(1, 2, 3, 6'h20);
        imem[3]  = e_r(1, 2, 4, 6'h22);
        imem[4]  = e_r(1, 2, 5, 6'h24);
        imem[5]  = e_r(1, 2, 6, 6'h25);
        imem[6]  = e_r(2, 1, 7, 6'h2A);
        imem[7]  = e_r(1, 2, 8, 6'h2A);
        imem[8]  = e_i(6'h08, 0, 0, 9);
        imem[9]  = e_i(6'h08, 0, 10, 7);
        imem[10] = e_i(6'h2B, 0, 3, 0);
        imem[11] = e_i(6'h2B, 0, 4, 4);
        imem[12] = e_i(6'h2B, 0, 5, 8);
        imem[13] = e_i(6'h2B, 0, 6, 12);
        imem[14] = e_i(6'h2B, 0, 7, 16);
        imem[15] = e_i(6'h2B, 0, 8, 20);
        imem[16] = e_i(6'h2B, 0, 0, 24);
        imem[17] = e_i(6'h23, 0, 9, 0);
        imem[18] = e_i(6'h04, 9, 3, 2);
        imem[19] = e_i(6'h08, 0, 10, 1);
        imem[20] = e_i(6'h08, 0, 10, 1);
        imem[21] = e_i(6'h04, 1, 2, 5);
        imem[22] = e_i(6'h2B, 0, 9, 28);
        imem[23] = e_i(6'h2B, 0, 10, 32);
        imem[24] = {6'h02, 26'd26};
        imem[25] = e_i(6'h08, 0, 10, 99);
        imem[26] = e_i(6'h2B, 0, 10, 36);
        imem[27] = e_i(6'h04, 0, 0, -1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc after reset", pc, 32'd0);
    endtask

    task automatic t_flow();
        int idx = 0;
        int prv = -1;
        rst = 1'b0;
        for (int k = 0; k < 34; k++) begin
            if (prv == 18 || prv == 27) chk("R3 branch target", pc, 32'(idx * 4));
            else if (prv == 24)         chk("R4 jump target", pc, 32'(idx * 4));
            else if (prv >= 0)          chk("R2 increment", pc, 32'(idx * 4));
            if (idx == 18) chk("R10 zero on equal", 32'(zero), 32'd1);
            if (idx == 21) chk("R10 zero on unequal", 32'(zero), 32'd0);
            if (idx == 10) chk("R5 store data from rt", wdata, 32'd2);
            if (idx == 13) chk("R7 immediate operand", addr, 32'd12);
            prv = idx;
            idx = nxt_idx(idx);
            @(negedge clk);
        end
    endtask

    task automatic t_results();
        // R6: rd destination for register ops, rt destination for addi
        chk("R9 add", dmem[0], 32'd2);
        chk("R9 sub", dmem[1], 32'd8);
        chk("R9 and", dmem[2], 32'd5);
        chk("R7 sign-extended or", dmem[3], 32'hFFFF_FFFD);
        chk("R13 slt negative<positive", dmem[4], 32'd1);
        chk("R13 slt positive<negative", dmem[5], 32'd0);
        chk("R11 r0 ignores write", dmem[6], 32'd0);
        chk("R8 load write-back", dmem[7], 32'd2);
        chk("R12 skipped words no write", dmem[8], 32'd7);
        chk("R4 jump skips word", dmem[9], 32'd7);
        chk("R6 untouched word", dmem[10], 32'hDEAD_000A);
    endtask

    task automatic t_reset_again();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc after second reset", pc, 32'd0);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 5000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_load_program();
        t_reset();
        t_flow();
        t_results();
        t_reset_again();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule